// File: doc/BRIEF.md
# Dual-Format Serial Configuration Writer

This block lets a host processor load a small bank of configuration registers over a slow serial link. It accepts 16-bit control words, most significant bit first. The upper seven bits name a register and the lower nine bits carry its new contents. Two link formats share the same pins. The first is a three-wire format with a strobe, a clock and data. The second is a two-wire addressed bus with a clock and an open-drain data line. The format is fixed by the level of the strobe pin when reset is released. All serial pins pass through two-flop synchronisers. All edges are then detected in the system clock domain, which must run at least four times faster than the serial clock.

Three registers are held, at addresses 0, 1 and 2, and their reset contents are fixed. A word sent to address 7 restores all three to those values and raises a short software-reset pulse. A word sent to any other address is dropped. The two-wire side has a seven-state controller. TW_IDLE moves to TW_ADDR on a start. TW_ADDR moves to TW_ACK_A when the address matches, and otherwise back to TW_IDLE. TW_ACK_A leads to TW_BYTE_HI, then TW_ACK_HI, then TW_BYTE_LO, then TW_ACK_LO, and finally back to TW_IDLE. A stop in any state returns the controller to TW_IDLE. A start outside TW_IDLE does the same. A disabled port stays in TW_IDLE. In each acknowledge state, the data line is pulled low from the serial clock fall that opens the slot until the next fall.

Top module: `ctl_serial_port`

## Requirements
- R1: The format is latched from the synchronised strobe pin on the third clock after reset release: low selects two-wire, high selects three-wire. Traffic in the other format then has no effect on the registers or on the pull output.
- R2: After reset the registers read 9'h003 (address 0), 9'h00A (address 1) and 9'h003 (address 2). The pull output and the software-reset output are low.
- R3: In three-wire mode, each serial clock rise shifts in one data bit. A strobe rise commits the last 16 bits, with bits 15..9 as the address and bits 8..0 as the data.
- R4: In two-wire mode, after a start (data falls while the clock is high), the byte 7'b0011010 followed by a write bit of 0 is acknowledged. The port pulls data low for the ninth clock.
- R5: Any other device address, or a read bit of 1, gets no acknowledge, and the next bytes are ignored until a new start.
- R6: After the address, a high byte (word bits 15..8) and then a low byte (bits 7..0) are each acknowledged. The register is written once the low byte's eighth bit has been taken.
- R7: A stop (data rises while the clock is high) or a start seen before the write completes returns the port to idle with no write.
- R8: A word to address 7, with any data, restores all three reset values and drives the software-reset output high for exactly 4 clock cycles.
- R9: A further committed word while the software reset is high ends the pulse early.
- R10: Words to addresses other than 0, 1, 2 and 7 change no register. In two-wire mode they are still acknowledged.
- R11: The pull output is asserted only in two-wire mode and only inside an acknowledge state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock |
| sdat_i | input | 1 | Serial data (line level in two-wire mode) |
| ssel_i | input | 1 | Format select at reset; three-wire commit strobe afterwards |
| sdat_pull_o | output | 1 | Pull-low enable for the two-wire data line |
| fmt_cfg_o | output | 9 | Register at address 0 |
| link_cfg_o | output | 9 | Register at address 1 |
| ctrl_cfg_o | output | 9 | Register at address 2 |
| soft_rst_o | output | 1 | Software-reset pulse |

## Verification
Two functions can act on the same clock: a word commit and the countdown that ends the software-reset pulse. The test provokes this in three-wire mode. It commits an address-7 word, then drops the strobe, clocks in one more zero bit and raises the strobe again, all on consecutive clocks. The new commit lands inside the pulse. The shifted word decodes as address 14, so the register values must stay at their reset contents. The bench counts the pulse width and expects it to end at 3 cycles instead of 4.

// File: rtl/ctlp_pkg.sv
package ctlp_pkg;
    localparam int ADDR_W    = 7;
    localparam int DATA_W    = 9;
    localparam int WORD_W    = ADDR_W + DATA_W;
    localparam int BYTE_W    = 8;
    localparam int NREG      = 3;
    localparam int SRST_CYC  = 4;
    localparam int SYNC_LAT  = 2;
    localparam logic [ADDR_W-1:0] DEV_ADDR  = 7'b0011010;
    localparam logic [ADDR_W-1:0] SRST_ADDR = 7'd7;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_t;

    typedef enum logic [2:0] {
        TW_IDLE,
        TW_ADDR,
        TW_ACK_A,
        TW_BYTE_HI,
        TW_ACK_HI,
        TW_BYTE_LO,
        TW_ACK_LO
    } tw_state_t;

    function automatic logic [DATA_W-1:0] reg_default(input int idx);
        case (idx)
            0:       return 9'h003;
            1:       return 9'h00A;
            2:       return 9'h003;
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/ctlp_sync.sv
module ctlp_sync #(
    parameter int            W   = 3,
    parameter logic [W-1:0]  RST = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o,
    output logic [W-1:0] qd_o
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST;
            q_o    <= RST;
            qd_o   <= RST;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
            qd_o   <= q_o;
        end
    end
endmodule

// File: rtl/ctlp_wire3.sv
module ctlp_wire3 import ctlp_pkg::*; (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic clk_rise_i,
    input  logic dat_i,
    input  logic sel_rise_i,
    output wr_t  wr_o
);
    logic [WORD_W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
            wr_o <= '0;
        end else begin
            wr_o.vld <= en_i && sel_rise_i;
            if (en_i && sel_rise_i) begin
                wr_o.addr <= sh_q[WORD_W-1 -: ADDR_W];
                wr_o.data <= sh_q[DATA_W-1:0];
            end
            if (en_i && clk_rise_i) begin
                sh_q <= {sh_q[WORD_W-2:0], dat_i};
            end
        end
    end
endmodule

// File: rtl/ctlp_wire2.sv
module ctlp_wire2 import ctlp_pkg::*; #(
    parameter logic [ADDR_W-1:0] DEV = DEV_ADDR
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic scl_i,
    input  logic scl_d_i,
    input  logic sda_i,
    input  logic sda_d_i,
    output logic pull_o,
    output logic in_ack_o,
    output wr_t  wr_o
);
    localparam int BW = $clog2(BYTE_W);

    tw_state_t         st_q, st_n;
    logic [BW-1:0]     bit_q;
    logic [BYTE_W-1:0] sh_q, hi_q;
    logic              scl_rise, scl_fall, scl_hold;
    logic              start_c, stop_c, last_bit, in_byte;
    logic [BYTE_W-1:0] byte_in;

    function automatic logic is_ack(input tw_state_t s);
        return (s == TW_ACK_A) || (s == TW_ACK_HI) || (s == TW_ACK_LO);
    endfunction

    assign scl_rise = scl_i && !scl_d_i;
    assign scl_fall = !scl_i && scl_d_i;
    assign scl_hold = scl_i && scl_d_i;
    assign start_c  = en_i && scl_hold && sda_d_i && !sda_i;
    assign stop_c   = en_i && scl_hold && !sda_d_i && sda_i;
    assign last_bit = scl_rise && (bit_q == BW'(BYTE_W - 1));
    assign byte_in  = {sh_q[BYTE_W-2:0], sda_i};
    assign in_byte  = (st_q == TW_ADDR) || (st_q == TW_BYTE_HI) || (st_q == TW_BYTE_LO);
    assign in_ack_o = is_ack(st_q);

    // next-state logic
    always_comb begin
        st_n = st_q;
        if (!en_i || stop_c) begin
            st_n = TW_IDLE;
        end else if (start_c) begin
            st_n = (st_q == TW_IDLE) ? TW_ADDR : TW_IDLE;
        end else begin
            unique case (st_q)
                TW_IDLE:    st_n = TW_IDLE;
                TW_ADDR:    if (last_bit) st_n = (byte_in == {DEV, 1'b0}) ? TW_ACK_A : TW_IDLE;
                TW_ACK_A:   if (scl_fall && pull_o) st_n = TW_BYTE_HI;
                TW_BYTE_HI: if (last_bit) st_n = TW_ACK_HI;
                TW_ACK_HI:  if (scl_fall && pull_o) st_n = TW_BYTE_LO;
                TW_BYTE_LO: if (last_bit) st_n = TW_ACK_LO;
                TW_ACK_LO:  if (scl_fall && pull_o) st_n = TW_IDLE;
                default:    st_n = TW_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TW_IDLE;
        else        st_q <= st_n;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q  <= '0;
            sh_q   <= '0;
            hi_q   <= '0;
            pull_o <= 1'b0;
            wr_o   <= '0;
        end else begin
            if (start_c) begin
                bit_q <= '0;
            end else if (en_i && in_byte && scl_rise) begin
                bit_q <= bit_q + 1'b1;
                sh_q  <= byte_in;
            end
            if (st_q == TW_BYTE_HI && last_bit) hi_q <= byte_in;
            pull_o   <= is_ack(st_n) && is_ack(st_q) && (scl_fall ? !pull_o : pull_o);
            wr_o.vld <= (st_q == TW_BYTE_LO) && (st_n == TW_ACK_LO);
            if ((st_q == TW_BYTE_LO) && (st_n == TW_ACK_LO)) begin
                wr_o.addr <= hi_q[BYTE_W-1 -: ADDR_W];
                wr_o.data <= {hi_q[0], byte_in};
            end
        end
    end
endmodule

// File: rtl/ctlp_regs.sv
module ctlp_regs import ctlp_pkg::*; #(
    parameter int SRST_LEN = SRST_CYC
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  wr_t                          wr_i,
    output logic [NREG-1:0][DATA_W-1:0]  cfg_o,
    output logic                         srst_o
);
    localparam int CW = (SRST_LEN > 1) ? $clog2(SRST_LEN) : 1;

    logic          hit_rst;
    logic [CW-1:0] cnt_q;

    assign hit_rst = wr_i.vld && (wr_i.addr == SRST_ADDR);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DATA_W-1:0] r_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                           r_q <= reg_default(g);
            else if (hit_rst)                                     r_q <= reg_default(g);
            else if (wr_i.vld && (wr_i.addr == ADDR_W'(g)))       r_q <= wr_i.data;
        end
        assign cfg_o[g] = r_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            srst_o <= 1'b0;
            cnt_q  <= '0;
        end else if (hit_rst) begin
            srst_o <= 1'b1;
            cnt_q  <= '0;
        end else if (srst_o) begin
            if (wr_i.vld || (cnt_q == CW'(SRST_LEN - 1))) srst_o <= 1'b0;
            else                                          cnt_q  <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ctl_serial_port.sv
module ctl_serial_port import ctlp_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              sdat_i,
    input  logic              ssel_i,
    output logic              sdat_pull_o,
    output logic [DATA_W-1:0] fmt_cfg_o,
    output logic [DATA_W-1:0] link_cfg_o,
    output logic [DATA_W-1:0] ctrl_cfg_o,
    output logic              soft_rst_o
);
    localparam int BOOT_W = $clog2(SYNC_LAT + 1);

    logic [2:0]                 s_q, s_d;
    logic [BOOT_W-1:0]          boot_q;
    logic                       ready_q, mode_3w_q;
    logic                       en3, en2, tw_in_ack;
    wr_t                        wr3, wr2, wr_m;
    logic [NREG-1:0][DATA_W-1:0] cfg;

    ctlp_sync #(.W(3), .RST(3'b111)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({ssel_i, sdat_i, sclk_i}),
        .q_o  (s_q),
        .qd_o (s_d)
    );

    // format latch once the synchroniser holds a post-reset sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            boot_q    <= '0;
            ready_q   <= 1'b0;
            mode_3w_q <= 1'b0;
        end else if (!ready_q) begin
            if (boot_q == BOOT_W'(SYNC_LAT)) begin
                ready_q   <= 1'b1;
                mode_3w_q <= s_q[2];
            end else begin
                boot_q <= boot_q + 1'b1;
            end
        end
    end

    assign en3 = ready_q && mode_3w_q;
    assign en2 = ready_q && !mode_3w_q;

    ctlp_wire3 i_wire3 (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en3),
        .clk_rise_i(s_q[0] && !s_d[0]),
        .dat_i     (s_q[1]),
        .sel_rise_i(s_q[2] && !s_d[2]),
        .wr_o      (wr3)
    );

    ctlp_wire2 #(.DEV(DEV_ADDR)) i_wire2 (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en2),
        .scl_i   (s_q[0]),
        .scl_d_i (s_d[0]),
        .sda_i   (s_q[1]),
        .sda_d_i (s_d[1]),
        .pull_o  (sdat_pull_o),
        .in_ack_o(tw_in_ack),
        .wr_o    (wr2)
    );

    assign wr_m = mode_3w_q ? wr3 : wr2;

    ctlp_regs #(.SRST_LEN(SRST_CYC)) i_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_i  (wr_m),
        .cfg_o (cfg),
        .srst_o(soft_rst_o)
    );

    assign fmt_cfg_o  = cfg[0];
    assign link_cfg_o = cfg[1];
    assign ctrl_cfg_o = cfg[2];
endmodule

// File: rtl/ctlp_chk.sv
module ctlp_chk import ctlp_pkg::*; (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_3w,
    input logic              ready,
    input logic              pull,
    input logic              in_ack,
    input logic              soft_rst,
    input logic [DATA_W-1:0] cfg0,
    input logic [DATA_W-1:0] cfg1,
    input logic [DATA_W-1:0] cfg2
);
    logic [$clog2(SRST_CYC)+1:0] w_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        w_q <= '0;
        else if (soft_rst) w_q <= w_q + 1'b1;
        else               w_q <= '0;
    end

    // R1
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(ready)) |-> $stable(mode_3w));

    // R11
    pull_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pull |-> (ready && !mode_3w));

    // R11
    pull_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pull |-> in_ack);

    // R8
    srst_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(soft_rst) |-> (cfg0 == reg_default(0) && cfg1 == reg_default(1) && cfg2 == reg_default(2)));

    // R8
    srst_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        w_q <= SRST_CYC);
endmodule

bind ctl_serial_port ctlp_chk i_ctlp_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_3w (mode_3w_q),
    .ready   (ready_q),
    .pull    (sdat_pull_o),
    .in_ack  (tw_in_ack),
    .soft_rst(soft_rst_o),
    .cfg0    (fmt_cfg_o),
    .cfg1    (link_cfg_o),
    .cfg2    (ctrl_cfg_o)
);

// File: tb/test_ctl_serial_port.sv
module test_ctl_serial_port;
    localparam int Q = 4;
    localparam logic [6:0] DEV = 7'b0011010;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       sdat_m = 1'b1;
    logic       ssel = 1'b1;
    logic       pull, srst;
    logic [8:0] c0, c1, c2;
    wire        sdat_line = sdat_m & ~pull;

    int vec = 0;
    int fail = 0;
    int srst_cnt = 0;
    logic [8:0] exp_r [3];

    always #5 clk = ~clk;

    ctl_serial_port i_ctl_serial_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_i     (sclk),
        .sdat_i     (sdat_line),
        .ssel_i     (ssel),
        .sdat_pull_o(pull),
        .fmt_cfg_o  (c0),
        .link_cfg_o (c1),
        .ctrl_cfg_o (c2),
        .soft_rst_o (srst)
    );

    always @(negedge clk) if (srst) srst_cnt++;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        vec++;
        if (act != exp) begin
            fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [8:0] dflt(input int i);
        return (i == 1) ? 9'h00A : 9'h003;
    endfunction

    task automatic model_write(input logic [6:0] a, input logic [8:0] d);
        if (a == 7'd7) begin
            for (int i = 0; i < 3; i++) exp_r[i] = dflt(i);
        end else if (a < 7'd3) begin
            exp_r[a] = d;
        end
    endtask

    task automatic check_regs(input string req);
        check(req, "reg0", int'(c0), int'(exp_r[0]));
        check(req, "reg1", int'(c1), int'(exp_r[1]));
        check(req, "reg2", int'(c2), int'(exp_r[2]));
    endtask

    task automatic do_reset(input logic sel_lvl, input logic clk_idle);
        rst_n = 1'b0;
        ssel  = sel_lvl;
        sclk  = clk_idle;
        sdat_m = 1'b1;
        tick(4);
        rst_n = 1'b1;
        tick(8);
        for (int i = 0; i < 3; i++) exp_r[i] = dflt(i);
    endtask

    task automatic shift3(input logic [15:0] w);
        ssel = 1'b0;
        tick(Q);
        for (int i = 15; i >= 0; i--) begin
            sdat_m = w[i];
            tick(Q);
            sclk = 1'b1;
            tick(Q);
            sclk = 1'b0;
            tick(Q);
        end
    endtask

    task automatic send3(input logic [15:0] w);
        shift3(w);
        ssel = 1'b1;
        tick(4 * Q);
    endtask

    task automatic tw_start;
        sdat_m = 1'b1; sclk = 1'b1; tick(Q);
        sdat_m = 1'b0; tick(Q);
        sclk = 1'b0; tick(Q);
    endtask

    task automatic tw_stop;
        sdat_m = 1'b0; tick(Q);
        sclk = 1'b1; tick(Q);
        sdat_m = 1'b1; tick(2 * Q);
    endtask

    task automatic tw_bit(input logic b);
        sdat_m = b; tick(Q);
        sclk = 1'b1; tick(2 * Q);
        sclk = 1'b0; tick(Q);
    endtask

    task automatic tw_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) tw_bit(b[i]);
        sdat_m = 1'b1; tick(Q);
        sclk = 1'b1; tick(Q);
        ack = !sdat_line;
        tick(Q);
        sclk = 1'b0; tick(Q);
    endtask

    task automatic tw_write(input logic [6:0] dev, input logic [15:0] w,
                            output logic a0, output logic a1, output logic a2);
        tw_start;
        tw_byte({dev, 1'b0}, a0);
        tw_byte(w[15:8], a1);
        tw_byte(w[7:0], a2);
        tw_stop;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", vec, fail);
        $finish;
    end

    initial begin
        logic a0, a1, a2;
        logic [6:0] ra;
        logic [8:0] rd;
        void'($urandom(32'd20251));

        // ---------------- three-wire phase ----------------
        do_reset(1'b1, 1'b0);
        // R2 reset contents
        check_regs("R2");
        check("R2", "pull", int'(pull), 0);
        check("R2", "soft_rst", int'(srst), 0);

        // R3 directed write
        send3({7'd1, 9'h155});
        model_write(7'd1, 9'h155);
        check_regs("R3");

        // R10 high address ignored
        send3({7'h7F, 9'h1FF});
        check_regs("R10");

        // R3 / R10 random words
        for (int n = 0; n < 20; n++) begin
            ra = 7'($urandom_range(0, 6));
            rd = 9'($urandom_range(0, 511));
            send3({ra, rd});
            model_write(ra, rd);
            check_regs(ra < 7'd3 ? "R3" : "R10");
        end

        // R1 two-wire traffic in three-wire mode
        sclk = 1'b0;
        tw_write(DEV, {7'd0, 9'h0AA}, a0, a1, a2);
        check("R1", "ack in 3-wire mode", int'(a0), 0);
        check_regs("R1");
        sclk = 1'b0; tick(Q);

        // R8 soft reset by address 7
        send3({7'd2, 9'h1E1});
        model_write(7'd2, 9'h1E1);
        check_regs("R3");
        srst_cnt = 0;
        send3({7'd7, 9'h0C3});
        model_write(7'd7, 9'h0C3);
        check("R8", "soft_rst cycles", srst_cnt, 4);
        check_regs("R8");

        // R9 commit inside the pulse, shortened to 3 cycles
        send3({7'd0, 9'h077});
        model_write(7'd0, 9'h077);
        srst_cnt = 0;
        shift3({7'd7, 9'h000});
        ssel = 1'b1;
        @(negedge clk); ssel = 1'b0;
        @(negedge clk); sdat_m = 1'b0; sclk = 1'b1;
        @(negedge clk); sclk = 1'b0; ssel = 1'b1;
        tick(20);
        model_write(7'd7, 9'h000);
        check("R9", "soft_rst cycles", srst_cnt, 3);
        check_regs("R9");

        // ---------------- two-wire phase ----------------
        do_reset(1'b0, 1'b1);
        check_regs("R2");
        check("R2", "pull", int'(pull), 0);

        // R4 / R6 directed write
        tw_write(DEV, {7'd1, 9'h1A5}, a0, a1, a2);
        model_write(7'd1, 9'h1A5);
        check("R4", "address ack", int'(a0), 1);
        check("R6", "high byte ack", int'(a1), 1);
        check("R6", "low byte ack", int'(a2), 1);
        check_regs("R6");

        // R6 / R10 random writes
        for (int n = 0; n < 12; n++) begin
            ra = 7'($urandom_range(0, 6));
            rd = 9'($urandom_range(0, 511));
            tw_write(DEV, {ra, rd}, a0, a1, a2);
            model_write(ra, rd);
            check("R4", "address ack", int'(a0), 1);
            check(ra < 7'd3 ? "R6" : "R10", "data acks", int'(a1 & a2), 1);
            check_regs(ra < 7'd3 ? "R6" : "R10");
        end

        // R5 wrong device, then read request
        tw_write(7'h1B, {7'd0, 9'h100}, a0, a1, a2);
        check("R5", "wrong address ack", int'(a0 | a1 | a2), 0);
        check_regs("R5");
        tw_start;
        tw_byte({DEV, 1'b1}, a0);
        tw_stop;
        check("R5", "read ack", int'(a0), 0);

        // R7 stop inside low byte
        tw_start;
        tw_byte({DEV, 1'b0}, a0);
        tw_byte({7'd2, 1'b0}, a1);
        for (int i = 0; i < 4; i++) tw_bit(1'b1);
        tw_stop;
        check_regs("R7");

        // R7 start inside low byte
        tw_start;
        tw_byte({DEV, 1'b0}, a0);
        tw_byte({7'd0, 1'b1}, a1);
        for (int i = 0; i < 3; i++) tw_bit(1'b0);
        sdat_m = 1'b1; tick(Q);
        sclk = 1'b1; tick(Q);
        sdat_m = 1'b0; tick(Q);
        for (int i = 0; i < 5; i++) tw_bit(1'b1);
        tw_stop;
        check_regs("R7");

        // R1 three-wire strobes in two-wire mode
        sclk = 1'b0; tick(Q);
        send3({7'd2, 9'h0F0});
        sdat_m = 1'b1; sclk = 1'b1; tick(2 * Q);
        check_regs("R1");

        // R8 soft reset over two-wire
        srst_cnt = 0;
        tw_write(DEV, {7'd7, 9'h1FF}, a0, a1, a2);
        model_write(7'd7, 9'h1FF);
        check("R8", "soft_rst cycles", srst_cnt, 4);
        check("R10", "ack on address 7", int'(a2), 1);
        check_regs("R8");

        $display("  == %0d vectors applied, %0d miscompares ==", vec, fail);
        $finish;
    end
endmodule